// File: doc/BRIEF.md
# Hardwired Step-Sequenced Processor Control

This block is a tiny processor built from a shared-bus datapath and a hardwired sequencer. A step counter walks through numbered timing steps. In each step, gates combine one decoded step line with one decoded opcode line to form a control word. The control word holds register load enables, bus drive enables, a three-bit ALU function, memory strobes and an MBR source select. Nothing in the sequencer branches on the opcode as a case statement. Every control bit is an OR of AND terms.

The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register, two data registers (R0 and R1) and a zero flag. Two operand buses feed the ALU. The ALU result bus feeds every register. The MBR loads either from memory read data or from the ALU result.

The block connects to a word-addressed memory with a combinational read. The memory writes on the clock edge while the write strobe is high. Each instruction takes four fetch steps followed by one or three execute steps.

Top module: `mstep_core`

## Requirements
- R1: A synchronous active-high `rst` clears PC, the step counter, the Z flag, R0 and R1. While `rst` is held, `fetchStart` is 1, `pcOut` is 0 and `zOut` is 0.
- R2: Fetch takes steps 0 to 3. In step 2, `memRd` is 1 and `memAddr` equals the PC value from the start of the instruction. PC advances by one and wraps from 31 to 0. The step counter never passes 6.
- R3: An instruction byte carries the opcode in bits 7:5 and an address in bits 4:0. The opcodes are LOAD=000, STORE=001, ADD=010, BRA=011 and BEQ=100.
- R4: LOAD sets R0 to the memory word at the address field. It lasts 7 cycles, and its second memory read occurs in step 5.
- R5: STORE writes R1 to the memory word at the address field. It does this in step 6 only, with `memAddr` set to that address, and it lasts 7 cycles.
- R6: ADD sets R1 to (R1 + R0) mod 256 and sets Z to 1 exactly when that result is zero. It lasts 5 cycles.
- R7: BRA sets PC to the address field. It lasts 5 cycles.
- R8: BEQ sets PC to the address field when Z is 1. Otherwise PC keeps the incremented value. BEQ leaves Z unchanged and lasts 5 cycles.
- R9: Opcodes 101, 110 and 111 change only PC, which advances by one. They last 5 cycles.
- R10: Only ADD and reset change Z.
- R11: At most one source drives each operand bus in any step, and `memRd` and `memWr` are never high together.
- R12: `memRd` is high only in fetch step 2 and in LOAD step 5. `memWr` is high only in STORE step 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memRData | input | 8 | Memory read data for the current address |
| memAddr | output | 5 | Memory word address (MAR) |
| memWData | output | 8 | Memory write data (MBR) |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe, takes effect at the clock edge |
| fetchStart | output | 1 | High in step 0, at each instruction boundary |
| pcOut | output | 5 | Program counter |
| r0Out | output | 8 | Register R0 |
| r1Out | output | 8 | Register R1 |
| zOut | output | 1 | Zero flag |

## Verification
A bad step count or control term shows up within one instruction. It appears as a missing or misplaced memory strobe in the per-step strobe comparison, or as `fetchStart` arriving in the wrong cycle. Corrupted register, flag or PC state shows up at the next instruction boundary, where all four visible registers are compared with an arithmetic model. A stray memory write surfaces at once through the write strobe check, and again in the full memory comparison at the end of each program. Programs that rewrite themselves and branch at random spread any such error into the fetch stream, so one slip quickly diverges from the model.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

  // ALU function codes carried in the control word
  localparam logic [2:0] FN_PASS_B = 3'b000;
  localparam logic [2:0] FN_PASS_C = 3'b001;
  localparam logic [2:0] FN_ADD    = 3'b010;
  localparam logic [2:0] FN_INC_B  = 3'b011;

  // opcode values (instruction bits 7:5)
  localparam int OPC_LOAD  = 0;
  localparam int OPC_STORE = 1;
  localparam int OPC_ADD   = 2;
  localparam int OPC_BRA   = 3;
  localparam int OPC_BEQ   = 4;
  localparam int OPC_FIRST_UNUSED = 5;

  typedef struct packed {
    logic       memRd;
    logic       memWr;
    logic       ldMar;
    logic       ldMbr;
    logic       ldPc;
    logic       ldIr;
    logic       ldR0;
    logic       ldR1;
    logic       ldZ;
    logic       bMbr;
    logic       bPc;
    logic       bIr;
    logic       bR0;
    logic       bR1;
    logic       cMbr;
    logic       cR0;
    logic       cR1;
    logic [2:0] aluFn;
    logic       mbrFromBus;
  } ctrlWord_t;

endpackage

// File: rtl/mstep_onehot_dec.sv
module mstep_onehot_dec #(
  parameter int IN_W = 3,
  localparam int OUT_N = 1 << IN_W
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] lines
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign lines[i] = (code == IN_W'(i));
  end
endmodule

// File: rtl/mstep_alu.sv
module mstep_alu import mstep_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        fn,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (fn)
      FN_PASS_B: res = opB;
      FN_PASS_C: res = opC;
      FN_ADD:    res = opB + opC;
      FN_INC_B:  res = opB + DATA_W'(1);
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/mstep_control.sv
module mstep_control import mstep_pkg::*; #(
  parameter int OP_W   = 3,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              zFlag,
  output ctrlWord_t         cw,
  output logic [STEP_W-1:0] stepNow
);
  localparam int NSTEP = 1 << STEP_W;
  localparam int NOPC  = 1 << OP_W;

  logic [STEP_W-1:0] step;
  logic [NSTEP-1:0]  t;
  logic [NOPC-1:0]   op;
  logic isLoad, isStore, isAdd, isBra, isBeq, isNop, lastStep;

  mstep_onehot_dec #(.IN_W(STEP_W)) u_stepDec (.code(step),   .lines(t));
  mstep_onehot_dec #(.IN_W(OP_W))   u_opDec   (.code(opcode), .lines(op));

  assign isLoad  = op[OPC_LOAD];
  assign isStore = op[OPC_STORE];
  assign isAdd   = op[OPC_ADD];
  assign isBra   = op[OPC_BRA];
  assign isBeq   = op[OPC_BEQ];
  assign isNop   = |op[NOPC-1:OPC_FIRST_UNUSED];

  // sum-of-products control terms: step line AND instruction line
  always_comb begin
    cw.memRd      = t[2] | (t[5] & isLoad);
    cw.memWr      = t[6] & isStore;
    cw.ldMar      = t[0] | (t[4] & isLoad) | (t[5] & isStore);
    cw.ldMbr      = t[2] | (t[5] & isLoad) | (t[4] & isStore);
    cw.mbrFromBus = t[4] & isStore;
    cw.ldPc       = t[1] | (t[4] & isBra) | (t[4] & isBeq & zFlag);
    cw.ldIr       = t[3];
    cw.ldR0       = t[6] & isLoad;
    cw.ldR1       = t[4] & isAdd;
    cw.ldZ        = t[4] & isAdd;
    cw.bPc        = t[0] | t[1];
    cw.bMbr       = t[3] | (t[6] & isLoad);
    cw.bIr        = (t[4] & isLoad) | (t[5] & isStore) | (t[4] & (isBra | isBeq));
    cw.bR0        = t[4] & isAdd;
    cw.bR1        = 1'b0;
    cw.cMbr       = 1'b0;
    cw.cR0        = 1'b0;
    cw.cR1        = t[4] & (isStore | isAdd);
    cw.aluFn[0]   = t[1] | (t[4] & isStore);
    cw.aluFn[1]   = t[1] | (t[4] & isAdd);
    cw.aluFn[2]   = 1'b0;
  end

  assign lastStep = (t[6] & (isLoad | isStore))
                  | (t[4] & (isAdd | isBra | isBeq | isNop))
                  | t[7];

  always_ff @(posedge clk) begin
    if (rst || lastStep) step <= '0;
    else                 step <= step + STEP_W'(1);
  end

  assign stepNow = step;
endmodule

// File: rtl/mstep_datapath.sv
module mstep_datapath import mstep_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  localparam int OP_W  = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlWord_t         cw,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [OP_W-1:0]   irOp,
  output logic              zFlag,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] r0Out,
  output logic [DATA_W-1:0] r1Out
);
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, r0, r1;
  logic              z;
  logic [DATA_W-1:0] busB, busC, aluOut;

  // wired-OR operand buses; the control keeps each one single-sourced
  assign busB = ({DATA_W{cw.bMbr}} & mbr)
              | ({DATA_W{cw.bPc}}  & DATA_W'(pc))
              | ({DATA_W{cw.bIr}}  & DATA_W'(ir[ADDR_W-1:0]))
              | ({DATA_W{cw.bR0}}  & r0)
              | ({DATA_W{cw.bR1}}  & r1);

  assign busC = ({DATA_W{cw.cMbr}} & mbr)
              | ({DATA_W{cw.cR0}}  & r0)
              | ({DATA_W{cw.cR1}}  & r1);

  mstep_alu #(.DATA_W(DATA_W)) u_alu (
    .fn (cw.aluFn),
    .opB(busB),
    .opC(busC),
    .res(aluOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      r0  <= '0;
      r1  <= '0;
      z   <= 1'b0;
    end else begin
      if (cw.ldPc)  pc  <= aluOut[ADDR_W-1:0];
      if (cw.ldMar) mar <= aluOut[ADDR_W-1:0];
      if (cw.ldMbr) mbr <= cw.mbrFromBus ? aluOut : memRData;
      if (cw.ldIr)  ir  <= aluOut;
      if (cw.ldR0)  r0  <= aluOut;
      if (cw.ldR1)  r1  <= aluOut;
      if (cw.ldZ)   z   <= (aluOut == '0);
    end
  end

  assign memAddr  = mar;
  assign memWData = mbr;
  assign irOp     = ir[DATA_W-1:ADDR_W];
  assign zFlag    = z;
  assign pcOut    = pc;
  assign r0Out    = r0;
  assign r1Out    = r1;
endmodule

// File: rtl/mstep_core.sv
module mstep_core import mstep_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              memRd,
  output logic              memWr,
  output logic              fetchStart,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] r0Out,
  output logic [DATA_W-1:0] r1Out,
  output logic              zOut
);
  localparam int OP_W = DATA_W - ADDR_W;

  ctrlWord_t         ctrlNow;
  logic [STEP_W-1:0] stepNow;
  logic [OP_W-1:0]   irOp;
  logic              zFlag;

  mstep_control #(.OP_W(OP_W), .STEP_W(STEP_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (irOp),
    .zFlag  (zFlag),
    .cw     (ctrlNow),
    .stepNow(stepNow)
  );

  mstep_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cw      (ctrlNow),
    .memRData(memRData),
    .memAddr (memAddr),
    .memWData(memWData),
    .irOp    (irOp),
    .zFlag   (zFlag),
    .pcOut   (pcOut),
    .r0Out   (r0Out),
    .r1Out   (r1Out)
  );

  assign memRd      = ctrlNow.memRd;
  assign memWr      = ctrlNow.memWr;
  assign fetchStart = (stepNow == '0);
  assign zOut       = zFlag;
endmodule

// File: rtl/mstep_core_chk.sv
module mstep_core_chk import mstep_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input ctrlWord_t         cw,
  input logic [STEP_W-1:0] step,
  input logic [ADDR_W-1:0] pcOut,
  input logic              zOut,
  input logic              memRd,
  input logic              memWr
);
  p_bus_b_single_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.bMbr, cw.bPc, cw.bIr, cw.bR0, cw.bR1}));

  p_bus_c_single_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cw.cMbr, cw.cR0, cw.cR1}));

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pcOut == '0 && !zOut && step == '0));

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_W'(1)) |=> (pcOut == $past(pcOut) + ADDR_W'(1)));

  p_step_range_r2: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(6));

  p_z_only_add_r10: assert property (@(posedge clk) disable iff (rst)
    !cw.ldZ |=> $stable(zOut));
endmodule

bind mstep_core mstep_core_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .cw   (ctrlNow),
  .step (stepNow),
  .pcOut(pcOut),
  .zOut (zOut),
  .memRd(memRd),
  .memWr(memWr)
);

// File: tb/mstep_core_test.sv
module mstep_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] memRData;
  logic [4:0] memAddr;
  logic [7:0] memWData;
  logic       memRd, memWr, fetchStart, zOut;
  logic [4:0] pcOut;
  logic [7:0] r0Out, r1Out;

  logic [7:0] mem [32];
  logic [7:0] mdlMem [32];
  logic [4:0] mPc;
  logic [7:0] mR0, mR1;
  logic       mZ;
  logic [15:0] lfsr;
  int checks = 0;
  int fails = 0;
  int beqTaken = 0;

  always #2 clk = ~clk;

  mstep_core uut (
    .clk(clk), .rst(rst), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .memRd(memRd), .memWr(memWr),
    .fetchStart(fetchStart), .pcOut(pcOut), .r0Out(r0Out),
    .r1Out(r1Out), .zOut(zOut)
  );

  assign memRData = mem[memAddr];
  always @(posedge clk) if (memWr) mem[memAddr] <= memWData;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic fillMem(input int mode);
    for (int a = 0; a < 32; a++) begin
      logic [7:0] v;
      if (mode == 0) v = 8'h00;
      else begin
        lfsr = nextLfsr(lfsr);
        case (lfsr[2:0])
          3'd0: v = 8'h00;
          3'd1: v = 8'hFF;
          3'd2: v = 8'h01;
          default: v = lfsr[15:8];
        endcase
      end
      mem[a] = v;
      mdlMem[a] = v;
    end
    if (mode == 0) begin
      // directed: zero sum, BEQ taken, store, BEQ not taken, unused opcode, PC wrap
      mem[0]  = 8'h14; mem[1]  = 8'h40; mem[2]  = 8'h85; mem[5]  = 8'h35;
      mem[6]  = 8'h16; mem[7]  = 8'h40; mem[8]  = 8'h80; mem[9]  = 8'hE0;
      mem[10] = 8'h7F; mem[31] = 8'h16; mem[20] = 8'h00; mem[22] = 8'h01;
      mem[3]  = 8'h63;
      for (int a = 0; a < 32; a++) mdlMem[a] = mem[a];
    end
  endtask

  task automatic runProgram(input int mode, input int nInstr);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    fillMem(mode);
    // R1: reset state seen at the ports
    chk(pcOut == 5'd0,   "R1 pc after reset", pcOut, 0);
    chk(zOut == 1'b0,    "R1 z after reset", zOut, 0);
    chk(r0Out == 8'd0 && r1Out == 8'd0, "R1 data regs after reset", {r0Out, r1Out}, 0);
    chk(fetchStart == 1'b1, "R1 step zero after reset", fetchStart, 1);
    rst = 1'b0;
    mPc = 0; mR0 = 0; mR1 = 0; mZ = 0;
    for (int k = 0; k < nInstr; k++) begin
      logic [7:0] ins;
      logic [2:0] opc;
      logic [4:0] adr, pcStart;
      logic [7:0] oldR1;
      int len;
      string tag;
      pcStart = mPc;
      ins = mdlMem[mPc];
      opc = ins[7:5];
      adr = ins[4:0];
      oldR1 = mR1;
      mPc = mPc + 5'd1;
      case (opc)
        3'd0: begin len = 7; tag = "R4 LOAD"; mR0 = mdlMem[adr]; end
        3'd1: begin len = 7; tag = "R5 STORE"; mdlMem[adr] = mR1; end
        3'd2: begin len = 5; tag = "R6 ADD"; mR1 = mR1 + mR0; mZ = (mR1 == 8'd0); end
        3'd3: begin len = 5; tag = "R7 BRA"; mPc = adr; end
        3'd4: begin len = 5; tag = "R8 BEQ"; if (mZ) begin mPc = adr; beqTaken++; end end
        default: begin len = 5; tag = "R9 unused opcode"; end
      endcase
      for (int c = 0; c < len; c++) begin
        bit expRd, expWr;
        expRd = (c == 2) || (opc == 3'd0 && c == 5);
        expWr = (opc == 3'd1 && c == 6);
        chk(memRd == expRd, "R12 read strobe", memRd, expRd);
        chk(memWr == expWr, "R12 write strobe", memWr, expWr);
        chk(!(memRd && memWr), "R11 strobes exclusive", {memRd, memWr}, 0);
        if (c == 2) chk(memAddr == pcStart, "R2 fetch address", memAddr, pcStart);
        if (expWr) begin
          chk(memAddr == adr, "R5 store address", memAddr, adr);
          chk(memWData == oldR1, "R5 store data", memWData, oldR1);
        end
        @(negedge clk);
      end
      chk(fetchStart == 1'b1, {tag, " cycle count (R3 decode)"}, fetchStart, 1);
      chk(pcOut == mPc, {tag, " pc (R2)"}, pcOut, mPc);
      chk(r0Out == mR0, {tag, " r0"}, r0Out, mR0);
      chk(r1Out == mR1, {tag, " r1"}, r1Out, mR1);
      chk(zOut == mZ, {tag, " z (R10)"}, zOut, mZ);
    end
    for (int a = 0; a < 32; a++)
      chk(mem[a] == mdlMem[a], "R5 memory image", mem[a], mdlMem[a]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    lfsr = 16'hACE1;
    @(negedge clk);
    runProgram(0, 14);
    chk(beqTaken > 0, "R8 taken branch occurred", beqTaken, 1);
    for (int s = 1; s <= 4; s++) begin
      lfsr = 16'h1234 + 16'(s * 977);
      runProgram(s, 1200);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule